// File: doc/BRIEF.md
# Maskable Interrupt Aggregator

This block gathers single-cycle event strobes from a framer and groups them into a fixed number of categories. Each category has one sticky status register. Every source bit in a category has its own mask bit. An event sets its status bit only when its mask bit is clear. While any status bit is set, the block pulls a shared, active-low request line down. The line is modelled as open drain: a constant-low data value plus an output enable. When every status register is empty, the enable drops and the line floats.

Software services the block through a plain read port. A read selects one category and returns that category's status register in the same cycle. The register is cleared at the next clock edge. A separate acknowledge bit gives a second way to clear. Whenever this bit changes level, in either direction, every status register is wiped at once. An event that arrives in the same cycle as a clear is kept, so no event is lost to a service race.

Top module: `irq_aggregator`

## Requirements
- R1: An event strobe on a source whose mask bit is 0 sets that source's status bit at the next clock edge.
- R2: An event strobe on a source whose mask bit is 1 leaves that source's status bit unchanged. Mask bit value 1 means suppressed.
- R3: A set status bit stays set until its category is read or the acknowledge bit changes level.
- R4: While `rd_en_i` is high, `rd_data_o` shows the status register of category `rd_sel_i` in the same cycle, where category c occupies bits [c*SRC_W +: SRC_W] of `evt_i` and `mask_i`. That register reads as zero after the following edge unless a new unmasked event arrived.
- R5: A read of one category leaves the status registers of all other categories untouched.
- R6: An unmasked event arriving in the same cycle as a clear of its register is kept: after the edge, the register holds exactly the events of that cycle.
- R7: Any level change of `ack_i` clears all status registers at the next edge. A steady `ack_i` has no effect.
- R8: `irq_oe_o` is 1 exactly when at least one status bit is set, and `irq_o` is always 0, so the line is driven low only while work is pending.
- R9: After reset, all status registers are zero and `irq_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | CAT_N*SRC_W | Event strobes, category c at bits [c*SRC_W +: SRC_W] |
| mask_i | input | CAT_N*SRC_W | Per-source mask, 1 suppresses the source |
| rd_en_i | input | 1 | Read strobe; clears the selected register at the edge |
| rd_sel_i | input | SEL_W | Category selected for reading |
| rd_data_o | output | SRC_W | Status register of the selected category |
| ack_i | input | 1 | Acknowledge bit; a level change clears everything |
| irq_o | output | 1 | Request line data value, constant 0 |
| irq_oe_o | output | 1 | Request line drive enable; 1 pulls the line low |

## Verification
The bench builds the block with its defaults: four categories of eight sources each, with a two-bit select. This is enough to exercise cross-category isolation, a single category holding several bits at once, and every select value, including the highest. Partial masks within one category show that suppression works per bit and not per category. Acknowledge toggles are applied in both directions and combined with simultaneous events, which exposes clear-versus-set priority at the register boundary.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned CAT_N_DEF = 4;
  localparam int unsigned SRC_W_DEF = 8;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_cat_reg.sv
module irq_cat_reg #(
  parameter int unsigned SRC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] evt_i,
  input  logic [SRC_W-1:0] mask_i,
  input  logic             clr_i,
  output logic [SRC_W-1:0] stat_o,
  output logic             any_o
);
  logic [SRC_W-1:0] hit;
  logic [SRC_W-1:0] stat_q;

  assign hit = evt_i & ~mask_i;

  // clear takes the current cycle's hits so nothing is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stat_q <= '0;
    else if (clr_i) stat_q <= hit;
    else            stat_q <= stat_q | hit;
  end

  assign stat_o = stat_q;
  assign any_o  = |stat_q;

  // R1
  evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit) |=> ((stat_o & $past(hit)) == $past(hit)));

  // R2
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_o & ~$past(stat_o) & ~$past(hit)) == '0));

  // R3
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

  // R6
  clr_keeps_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (stat_o == $past(hit)));
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux #(
  parameter int unsigned CAT_N = 4,
  parameter int unsigned SRC_W = 8,
  parameter int unsigned SEL_W = 2
) (
  input  logic                   rd_en_i,
  input  logic [SEL_W-1:0]       rd_sel_i,
  input  logic [CAT_N*SRC_W-1:0] stat_i,
  output logic [SRC_W-1:0]       rd_data_o,
  output logic [CAT_N-1:0]       rd_clr_o
);
  logic [CAT_N-1:0] sel_hot;

  for (genvar c = 0; c < CAT_N; c++) begin : g_sel
    assign sel_hot[c]  = (rd_sel_i == SEL_W'(c));
    assign rd_clr_o[c] = rd_en_i & sel_hot[c];
  end

  always_comb begin
    rd_data_o = '0;
    for (int c = 0; c < CAT_N; c++) begin
      if (sel_hot[c]) rd_data_o = stat_i[c*SRC_W +: SRC_W];
    end
  end

  // R5
  always_comb begin
    one_clear_chk: assert ($onehot0(rd_clr_o));
  end
endmodule

// File: rtl/irq_ack_tog.sv
module irq_ack_tog (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic tog_o
);
  logic ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= ack_i;
  end

  assign tog_o = ack_i ^ ack_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned CAT_N = CAT_N_DEF,
  parameter int unsigned SRC_W = SRC_W_DEF,
  localparam int unsigned SEL_W = idx_w(CAT_N),
  localparam int unsigned TOT_W = CAT_N * SRC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TOT_W-1:0] evt_i,
  input  logic [TOT_W-1:0] mask_i,
  input  logic             rd_en_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [SRC_W-1:0] rd_data_o,
  input  logic             ack_i,
  output logic             irq_o,
  output logic             irq_oe_o
);
  logic [TOT_W-1:0] stat_all;
  logic [CAT_N-1:0] cat_any;
  logic [CAT_N-1:0] rd_clr;
  logic             ack_tog;
  logic             hit_any;

  irq_ack_tog u_ack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ack_i  (ack_i),
    .tog_o  (ack_tog)
  );

  irq_rd_mux #(.CAT_N(CAT_N), .SRC_W(SRC_W), .SEL_W(SEL_W)) u_rd (
    .rd_en_i   (rd_en_i),
    .rd_sel_i  (rd_sel_i),
    .stat_i    (stat_all),
    .rd_data_o (rd_data_o),
    .rd_clr_o  (rd_clr)
  );

  for (genvar c = 0; c < CAT_N; c++) begin : g_cat
    irq_cat_reg #(.SRC_W(SRC_W)) u_cat (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt_i[c*SRC_W +: SRC_W]),
      .mask_i (mask_i[c*SRC_W +: SRC_W]),
      .clr_i  (rd_clr[c] | ack_tog),
      .stat_o (stat_all[c*SRC_W +: SRC_W]),
      .any_o  (cat_any[c])
    );
  end

  assign hit_any  = |(evt_i & ~mask_i);
  // open drain: data fixed low, enable pulls
  assign irq_o    = 1'b0;
  assign irq_oe_o = |cat_any;

  // R8
  line_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_any |=> irq_oe_o);

  // R8
  line_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_oe_o && !hit_any) |=> !irq_oe_o);

  // R7
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_tog && !hit_any) |=> !irq_oe_o);

  // R4
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !hit_any) |=>
      (stat_all[int'($past(rd_sel_i))*SRC_W +: SRC_W] == '0));
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  localparam int CAT_N = 4;
  localparam int SRC_W = 8;
  localparam int SEL_W = 2;
  localparam int TOT_W = CAT_N * SRC_W;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic [TOT_W-1:0] evt_i, mask_i;
  logic             rd_en_i, ack_i;
  logic [SEL_W-1:0] rd_sel_i;
  logic [SRC_W-1:0] rd_data_o;
  logic             irq_o, irq_oe_o;

  always #10 clk = ~clk;

  irq_aggregator u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .mask_i    (mask_i),
    .rd_en_i   (rd_en_i),
    .rd_sel_i  (rd_sel_i),
    .rd_data_o (rd_data_o),
    .ack_i     (ack_i),
    .irq_o     (irq_o),
    .irq_oe_o  (irq_oe_o)
  );

  typedef struct packed {
    logic        is_oe;
    logic [31:0] exp;
    logic [31:0] req;
  } chk_t;

  chk_t             q[$];
  event             push_ev;
  logic [SRC_W-1:0] m_reg [CAT_N];
  logic             m_ack;
  int               n_chk = 0;
  int               n_err = 0;
  bit               done  = 0;

  function automatic logic [TOT_W-1:0] ev(input int c, input int b);
    return TOT_W'(1) << (c*SRC_W + b);
  endfunction

  task automatic step(input logic [TOT_W-1:0] evt, input logic [TOT_W-1:0] msk,
                      input logic rd, input logic [SEL_W-1:0] sel,
                      input logic ack, input int req);
    logic any;
    logic clr_all;
    logic [SRC_W-1:0] hit;
    @(negedge clk);
    evt_i = evt; mask_i = msk; rd_en_i = rd; rd_sel_i = sel; ack_i = ack;
    #2;
    if (rd) begin
      q.push_back('{1'b0, 32'(m_reg[sel]), 32'(req)});
      -> push_ev;
    end
    clr_all = (ack != m_ack);
    m_ack   = ack;
    for (int c = 0; c < CAT_N; c++) begin
      hit = evt[c*SRC_W +: SRC_W] & ~msk[c*SRC_W +: SRC_W];
      if (clr_all || (rd && sel == SEL_W'(c))) m_reg[c] = hit;
      else                                     m_reg[c] = m_reg[c] | hit;
    end
    @(posedge clk);
    #2;
    any = 1'b0;
    for (int c = 0; c < CAT_N; c++) any = any | (|m_reg[c]);
    q.push_back('{1'b1, 32'(any), 32'(req)});
    -> push_ev;
  endtask

  task automatic rd(input int c, input logic ack, input int req);
    step('0, '0, 1'b1, SEL_W'(c), ack, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // monitor
  initial begin
    chk_t it;
    forever begin
      @(push_ev);
      while (q.size() > 0) begin
        it = q.pop_front();
        n_chk++;
        if (it.is_oe) begin
          if (irq_oe_o !== it.exp[0] || irq_o !== 1'b0) begin
            n_err++;
            $display("FAIL R%0d: oe=%b irq=%b expected oe=%b irq=0",
                     it.req, irq_oe_o, irq_o, it.exp[0]);
          end
        end else if (rd_data_o !== it.exp[SRC_W-1:0]) begin
          n_err++;
          $display("FAIL R%0d: rd_data=%h expected %h",
                   it.req, rd_data_o, it.exp[SRC_W-1:0]);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    logic        ack_lvl;
    for (int c = 0; c < CAT_N; c++) m_reg[c] = '0;
    m_ack = 1'b0;
    rst_ni = 1'b0; evt_i = '0; mask_i = '0; rd_en_i = 1'b0; rd_sel_i = '0; ack_i = 1'b0;
    #45 rst_ni = 1'b1;

    // R9: line released and every register empty after reset
    @(negedge clk);
    q.push_back('{1'b1, 32'd0, 32'd9}); -> push_ev;
    for (int c = 0; c < CAT_N; c++) rd(c, 1'b0, 9); // R9

    // R1 then R4
    step(ev(0,3), '0, 1'b0, 0, 1'b0, 1);   // R1
    rd(0, 1'b0, 4);                        // R4 returns 08
    rd(0, 1'b0, 4);                        // R4 cleared

    // R2: full and partial masking
    step(ev(1,5), ev(1,5), 1'b0, 0, 1'b0, 2);              // R2
    rd(1, 1'b0, 2);
    step(ev(1,5) | ev(1,6), ev(1,5), 1'b0, 0, 1'b0, 2);    // R2
    rd(1, 1'b0, 2);

    // R3, R5, R8: two categories pending, read one at a time
    step(ev(2,0) | ev(3,7), '0, 1'b0, 0, 1'b0, 3);  // R3
    step('0, '0, 1'b0, 0, 1'b0, 3);
    step('0, '0, 1'b0, 0, 1'b0, 3);
    rd(2, 1'b0, 5);                                 // R5 cat3 kept, line low
    rd(3, 1'b0, 8);                                 // R8 last read releases
    rd(2, 1'b0, 5);

    // R6: event during read-clear of own category
    step(ev(0,1), '0, 1'b0, 0, 1'b0, 6);
    step(ev(0,2), '0, 1'b1, 0, 1'b0, 6);            // R6 returns 02
    rd(0, 1'b0, 6);                                 // R6 returns 04

    // R7: toggle up clears all, steady level no effect, toggle down with event
    step(ev(0,0) | ev(1,1) | ev(2,2) | ev(3,3), '0, 1'b0, 0, 1'b0, 7);
    step('0, '0, 1'b0, 0, 1'b1, 7);                 // R7 clear all
    step(ev(1,0), '0, 1'b0, 0, 1'b1, 7);            // R7 steady
    step('0, '0, 1'b0, 0, 1'b1, 7);
    rd(1, 1'b1, 7);
    step(ev(3,1), '0, 1'b0, 0, 1'b1, 7);
    step(ev(2,4), '0, 1'b0, 0, 1'b0, 7);            // R7 toggle down + event
    rd(2, 1'b0, 7);
    rd(3, 1'b0, 7);

    // mixed traffic, R1 R2 R4 R5 R7 together
    lfsr = 32'hACE1_2357;
    ack_lvl = 1'b0;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[5:0] == 6'h11) ack_lvl = ~ack_lvl;
      step(lfsr & {lfsr[15:0], lfsr[31:16]}, {lfsr[7:0], lfsr[31:8]},
           lfsr[9], lfsr[12:11], ack_lvl, 4);
    end
    for (int c = 0; c < CAT_N; c++) rd(c, ack_lvl, 4);

    #5;
    finish_run();
  end
endmodule